// File: doc/BRIEF.md
# Lockable Round-Robin Translation Buffer

This block is a small, fully associative store of recently used virtual-to-physical page translations. Every entry carries a virtual page tag, a physical page number, a page-size code, a protection domain and a set of access-permission bits. A lookup compares the presented virtual address against every entry in the same cycle. One cycle later it returns the translated physical address, the domain and the permission bits. When no entry matches, the lookup reports a miss and an external page-table walker supplies the translation through the refill port.

The lowest-numbered entries can be pinned by programming a lock count. Pinned entries are never chosen as victims, never overwritten and never cleared by a flush. New translations go into the unlocked entries in round-robin order. The pointer sweeps from the lock count up to the last entry and then wraps back to the lock count.

Top module: `xlat_cache`

## Requirements
- R1: After a synchronous reset every entry is invalid, the lock count is 0, the round-robin pointer is at entry 0, and `res_valid` and `res_hit` are low.
- R2: A lookup presented with `lkp_valid` high gives exactly one result, with `res_valid` high on the following cycle. `res_valid` is low in every cycle that follows a cycle without a request.
- R3: On a hit, the bits of `res_paddr` above the page offset come from the entry's physical page. The offset bits come from the lookup address. `res_domain` and `res_perm` come from the same entry.
- R4: The size codes and their page offsets are: 2'b00 is a 1 MB page with a 20-bit offset, 2'b01 is 64 KB with 16 bits, 2'b10 is 4 KB with 12 bits, and 2'b11 is 1 KB with 10 bits. Only address bits above an entry's offset take part in its tag compare.
- R5: On a miss, `res_hit` is low and `res_paddr`, `res_domain` and `res_perm` are all zero.
- R6: A refill that matches no entry is written at the round-robin pointer, and the pointer then advances by one. From the last entry the pointer wraps to the lock count, not to 0. Hits do not move the pointer.
- R7: A refill whose address matches a valid unlocked entry overwrites that entry in place. It does not allocate a second copy and does not move the pointer.
- R8: `flush` clears the valid bit of every entry whose index is at or above the lock count. Locked entries and the pointer are unchanged.
- R9: Entries below the lock count are never written. A refill whose lowest-index match is a locked entry is dropped.
- R10: `lock_set` loads the lock count from `lock_count`, with values above the depth clamped to the depth. A pointer below the new count moves up to it. While every entry is locked, a refill that matches no entry is dropped.
- R11: A lookup in the same cycle as a refill sees the contents from before that refill.
- R12: A refill presented in the same cycle as `flush` or `lock_set` is dropped.
- R13: When several valid entries match a lookup, the lowest-index entry supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_vaddr | input | ADDR_W | Virtual address to translate |
| res_valid | output | 1 | Result of the previous cycle's lookup |
| res_hit | output | 1 | Lookup found a translation |
| res_paddr | output | ADDR_W | Translated physical address, zero on miss |
| res_domain | output | DOM_W | Domain of the hit entry, zero on miss |
| res_perm | output | PERM_W | Access-permission bits of the hit entry, zero on miss |
| fill_valid | input | 1 | Refill request |
| fill_vpage | input | ADDR_W-10 | Virtual address bits above bit 9 |
| fill_ppage | input | ADDR_W-10 | Physical address bits above bit 9 |
| fill_size | input | 2 | Page-size code (R4) |
| fill_domain | input | DOM_W | Domain for the new entry |
| fill_perm | input | PERM_W | Access-permission bits for the new entry |
| flush | input | 1 | Invalidate all unlocked entries |
| lock_set | input | 1 | Load a new lock count |
| lock_count | input | clog2(DEPTH+1) | Number of locked low entries |

## Verification
The assertions require `lock_count` to lie within the depth, which the block's clamp guarantees. They also require that an entry below the lock count holds valid data before its contents are compared across a cycle, so the hold check on locked entries applies only to valid entries. The stimulus pulses `flush` and `lock_set` one at a time except where R12 is deliberately exercised. It tracks the round-robin pointer by hand through sequences of distinct 4 KB pages, and it places overlapping pages only where R13 is being checked.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

  // Smallest page offset; all tags are stored from this bit upward.
  localparam int unsigned MIN_SHIFT = 10;

  typedef enum logic [1:0] {
    PG_SECTION = 2'b00,
    PG_LARGE   = 2'b01,
    PG_SMALL   = 2'b10,
    PG_TINY    = 2'b11
  } pg_size_e;

  // Number of page-offset bits for each size code.
  function automatic int unsigned pg_shift(input pg_size_e s);
    case (s)
      PG_SECTION: pg_shift = 20;
      PG_LARGE:   pg_shift = 16;
      PG_SMALL:   pg_shift = 12;
      default:    pg_shift = 10;
    endcase
  endfunction

endpackage

// File: rtl/xlat_tag_cmp.sv
module xlat_tag_cmp
  import xlat_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int TAG_W = ADDR_W - MIN_SHIFT
) (
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [1:0]       ent_size,
  input  logic [TAG_W-1:0] probe_lkp,
  input  logic [TAG_W-1:0] probe_fill,
  output logic             hit_lkp,
  output logic             hit_fill,
  output logic [TAG_W-1:0] page_mask
);

  int unsigned drop_bits;

  always_comb begin
    drop_bits = pg_shift(pg_size_e'(ent_size)) - MIN_SHIFT;
    page_mask = ~((TAG_W'(1) << drop_bits) - TAG_W'(1));
    hit_lkp   = ent_valid && (((ent_tag ^ probe_lkp) & page_mask) == '0);
    hit_fill  = ent_valid && (((ent_tag ^ probe_fill) & page_mask) == '0);
  end

endmodule

// File: rtl/xlat_rr_ptr.sv
module xlat_rr_ptr #(
  parameter int DEPTH = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int BASE_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_we,
  input  logic [BASE_W-1:0] lock_wdata,
  input  logic              advance,
  output logic [IDX_W-1:0]  victim,
  output logic [BASE_W-1:0] lock_base,
  output logic              all_locked
);

  logic [BASE_W-1:0] base_new;

  always_comb begin
    base_new   = (lock_wdata > BASE_W'(DEPTH)) ? BASE_W'(DEPTH) : lock_wdata;
    all_locked = (lock_base == BASE_W'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_base <= '0;
      victim    <= '0;
    end else if (lock_we) begin
      lock_base <= base_new;
      if (base_new == BASE_W'(DEPTH))
        victim <= '0;
      else if (BASE_W'(victim) < base_new)
        victim <= IDX_W'(base_new);
    end else if (advance) begin
      if (victim == IDX_W'(DEPTH - 1))
        victim <= IDX_W'(lock_base);
      else
        victim <= victim + IDX_W'(1);
    end
  end

  // R6: the pointer never rests inside the locked region
  p_window_r6: assert property (@(posedge clk) disable iff (rst)
    !all_locked |-> (BASE_W'(victim) >= lock_base));

  // R6: wrap from the last entry lands on the lock count
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (advance && !lock_we && victim == IDX_W'(DEPTH - 1))
      |=> (BASE_W'(victim) == $past(lock_base)));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DOM_W  = 4,
  parameter int PERM_W = 8,
  localparam int TAG_W  = ADDR_W - MIN_SHIFT,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int BASE_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_vaddr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [ADDR_W-1:0] res_paddr,
  output logic [DOM_W-1:0]  res_domain,
  output logic [PERM_W-1:0] res_perm,
  input  logic              fill_valid,
  input  logic [TAG_W-1:0]  fill_vpage,
  input  logic [TAG_W-1:0]  fill_ppage,
  input  logic [1:0]        fill_size,
  input  logic [DOM_W-1:0]  fill_domain,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush,
  input  logic              lock_set,
  input  logic [BASE_W-1:0] lock_count
);

  // Entry storage: flops, since every entry is compared in parallel.
  logic [DEPTH-1:0]  e_valid;
  logic [TAG_W-1:0]  e_tag  [DEPTH];
  logic [TAG_W-1:0]  e_pfn  [DEPTH];
  logic [1:0]        e_size [DEPTH];
  logic [DOM_W-1:0]  e_dom  [DEPTH];
  logic [PERM_W-1:0] e_perm [DEPTH];

  logic [DEPTH-1:0]  hit_lkp;
  logic [DEPTH-1:0]  hit_fill;
  logic [TAG_W-1:0]  e_mask [DEPTH];

  logic [IDX_W-1:0]  victim;
  logic [BASE_W-1:0] lock_base;
  logic              all_locked;
  logic              advance;
  logic [DEPTH-1:0]  wr_en;

  logic              lk_any;
  logic [IDX_W-1:0]  lk_idx;
  logic              fm_any;
  logic [IDX_W-1:0]  fm_idx;
  logic              fill_ok;
  logic [TAG_W-1:0]  lk_vtag;

  assign lk_vtag = lkp_vaddr[ADDR_W-1:MIN_SHIFT];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    xlat_tag_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .ent_valid  (e_valid[g]),
      .ent_tag    (e_tag[g]),
      .ent_size   (e_size[g]),
      .probe_lkp  (lk_vtag),
      .probe_fill (fill_vpage),
      .hit_lkp    (hit_lkp[g]),
      .hit_fill   (hit_fill[g]),
      .page_mask  (e_mask[g])
    );
  end

  xlat_rr_ptr #(.DEPTH(DEPTH)) u_rr (
    .clk        (clk),
    .rst        (rst),
    .lock_we    (lock_set),
    .lock_wdata (lock_count),
    .advance    (advance),
    .victim     (victim),
    .lock_base  (lock_base),
    .all_locked (all_locked)
  );

  // Lowest-index priority for both the lookup and the refill match.
  always_comb begin
    lk_any = 1'b0;
    lk_idx = '0;
    fm_any = 1'b0;
    fm_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_lkp[i]) begin
        lk_any = 1'b1;
        lk_idx = IDX_W'(i);
      end
      if (hit_fill[i]) begin
        fm_any = 1'b1;
        fm_idx = IDX_W'(i);
      end
    end
  end

  // Refill placement: overwrite an unlocked match, else allocate at victim.
  always_comb begin
    fill_ok = fill_valid && !flush && !lock_set;
    wr_en   = '0;
    advance = 1'b0;
    if (fill_ok) begin
      if (fm_any) begin
        if (BASE_W'(fm_idx) >= lock_base)
          wr_en[fm_idx] = 1'b1;
      end else if (!all_locked) begin
        wr_en[victim] = 1'b1;
        advance       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e_valid <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (flush && (BASE_W'(i) >= lock_base))
          e_valid[i] <= 1'b0;
        else if (wr_en[i])
          e_valid[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en[i]) begin
        e_tag[i]  <= fill_vpage;
        e_pfn[i]  <= fill_ppage;
        e_size[i] <= fill_size;
        e_dom[i]  <= fill_domain;
        e_perm[i] <= fill_perm;
      end
    end
  end

  // Registered lookup result.
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_paddr  <= '0;
      res_domain <= '0;
      res_perm   <= '0;
    end else begin
      res_valid <= lkp_valid;
      if (lkp_valid && lk_any) begin
        res_hit    <= 1'b1;
        res_paddr  <= {(e_pfn[lk_idx] & e_mask[lk_idx]) | (lk_vtag & ~e_mask[lk_idx]),
                       lkp_vaddr[MIN_SHIFT-1:0]};
        res_domain <= e_dom[lk_idx];
        res_perm   <= e_perm[lk_idx];
      end else begin
        res_hit    <= 1'b0;
        res_paddr  <= '0;
        res_domain <= '0;
        res_perm   <= '0;
      end
    end
  end

  // R2: one result per request, one cycle later
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    lkp_valid |=> res_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !lkp_valid |=> !res_valid);

  // R3: a hit is only reported with a result
  p_hit_valid_r3: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid);

  // R5: miss results carry zeros
  p_miss_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_paddr == '0 && res_domain == '0 && res_perm == '0));

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    // R8: flush empties every unlocked entry
    p_flush_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (flush && (BASE_W'(g) >= lock_base)) |=> !e_valid[g]);

    // R9: a valid locked entry keeps its contents
    p_locked_hold_r9: assert property (@(posedge clk) disable iff (rst)
      ((BASE_W'(g) < lock_base) && e_valid[g])
        |=> (e_valid[g] && $stable(e_tag[g]) && $stable(e_pfn[g])
             && $stable(e_dom[g]) && $stable(e_perm[g])));
  end

endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_vaddr = '0;
  logic        res_valid, res_hit;
  logic [31:0] res_paddr;
  logic [3:0]  res_domain;
  logic [7:0]  res_perm;
  logic        fill_valid = 1'b0;
  logic [21:0] fill_vpage = '0;
  logic [21:0] fill_ppage = '0;
  logic [1:0]  fill_size = '0;
  logic [3:0]  fill_domain = '0;
  logic [7:0]  fill_perm = '0;
  logic        flush = 1'b0;
  logic        lock_set = 1'b0;
  logic [3:0]  lock_count = '0;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit          hit;
    logic [31:0] pa;
    logic [3:0]  dom;
    logic [7:0]  perm;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk(clk), .rst(rst),
    .lkp_valid(lkp_valid), .lkp_vaddr(lkp_vaddr),
    .res_valid(res_valid), .res_hit(res_hit), .res_paddr(res_paddr),
    .res_domain(res_domain), .res_perm(res_perm),
    .fill_valid(fill_valid), .fill_vpage(fill_vpage), .fill_ppage(fill_ppage),
    .fill_size(fill_size), .fill_domain(fill_domain), .fill_perm(fill_perm),
    .flush(flush), .lock_set(lock_set), .lock_count(lock_count)
  );

  function automatic logic [31:0] va_of(int k);  return 32'h1000_0000 + (k << 12); endfunction
  function automatic logic [31:0] pa_of(int k);  return 32'h8000_0000 + (k << 12); endfunction
  function automatic logic [3:0]  dom_of(int k); return 4'(k); endfunction
  function automatic logic [7:0]  perm_of(int k); return 8'(k * 7 + 1); endfunction

  // Monitor: compare each result against the scoreboard head.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected result hit=%0b pa=%h, expected no result", res_hit, res_paddr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (res_hit !== e.hit || res_paddr !== e.pa || res_domain !== e.dom || res_perm !== e.perm) begin
          fails++;
          $display("FAIL %s: hit=%0b pa=%h dom=%h perm=%h, expected hit=%0b pa=%h dom=%h perm=%h",
                   e.req, res_hit, res_paddr, res_domain, res_perm, e.hit, e.pa, e.dom, e.perm);
        end
      end
    end
  end

  task automatic push_exp(bit hit, logic [31:0] pa, logic [3:0] dom, logic [7:0] perm, string req);
    exp_t e;
    e.hit = hit; e.req = req;
    e.pa   = hit ? pa   : 32'h0;
    e.dom  = hit ? dom  : 4'h0;
    e.perm = hit ? perm : 8'h0;
    sb.push_back(e);
  endtask

  task automatic lookup(logic [31:0] va, bit hit, logic [31:0] pa, logic [3:0] dom,
                        logic [7:0] perm, string req);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_vaddr = va;
    push_exp(hit, pa, dom, perm, req);
    @(negedge clk);
    lkp_valid = 1'b0;
  endtask

  task automatic look_pg(int k, bit hit, string req);
    lookup(va_of(k) + 32'h0AB, hit, pa_of(k) + 32'h0AB, dom_of(k), perm_of(k), req);
  endtask

  task automatic set_fill(logic [31:0] va, logic [1:0] sz, logic [31:0] pa, logic [3:0] d, logic [7:0] p);
    fill_valid = 1'b1; fill_vpage = va[31:10]; fill_ppage = pa[31:10];
    fill_size = sz; fill_domain = d; fill_perm = p;
  endtask

  task automatic fill(logic [31:0] va, logic [1:0] sz, logic [31:0] pa, logic [3:0] d, logic [7:0] p);
    @(negedge clk);
    set_fill(va, sz, pa, d, p);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic fill_pg(int k);
    fill(va_of(k), 2'b10, pa_of(k), dom_of(k), perm_of(k));
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic do_lock(int n);
    @(negedge clk); lock_set = 1'b1; lock_count = 4'(n);
    @(negedge clk); lock_set = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    checks++;
    if (res_valid !== 1'b0 || res_hit !== 1'b0) begin
      fails++;
      $display("FAIL R1: res_valid=%0b res_hit=%0b, expected 0 0", res_valid, res_hit);
    end
    look_pg(0, 1'b0, "R1");
    lookup(32'h003A_BCDE, 1'b0, 0, 0, 0, "R5");

    // R4 / R3: every page size
    fill(32'h0030_0000, 2'b00, 32'h0450_0000, 4'h1, 8'h03);
    lookup(32'h003A_BCDE, 1'b1, 32'h045A_BCDE, 4'h1, 8'h03, "R4");
    lookup(32'h0040_0000, 1'b0, 0, 0, 0, "R4");
    fill(32'h1234_0000, 2'b01, 32'h5678_0000, 4'h2, 8'h5A);
    lookup(32'h1234_F00D, 1'b1, 32'h5678_F00D, 4'h2, 8'h5A, "R4");
    lookup(32'h1235_0000, 1'b0, 0, 0, 0, "R4");
    fill(32'h2000_0400, 2'b11, 32'h3000_0800, 4'h3, 8'hC3);
    lookup(32'h2000_07FF, 1'b1, 32'h3000_0BFF, 4'h3, 8'hC3, "R4");
    lookup(32'h2000_0800, 1'b0, 0, 0, 0, "R4");
    fill(32'h4000_1000, 2'b10, 32'h7000_3000, 4'h4, 8'h81);
    lookup(32'h4000_1ABC, 1'b1, 32'h7000_3ABC, 4'h4, 8'h81, "R3");
    lookup(32'h4000_2000, 1'b0, 0, 0, 0, "R5");

    // R13: overlapping pages, lower index wins
    fill(32'h0050_1000, 2'b10, 32'h9000_0000, 4'h5, 8'h11);
    fill(32'h0050_0000, 2'b00, 32'hA000_0000, 4'h6, 8'h22);
    lookup(32'h0050_1234, 1'b1, 32'h9000_0234, 4'h5, 8'h11, "R13");
    lookup(32'h0050_2234, 1'b1, 32'hA000_2234, 4'h6, 8'h22, "R13");

    // R6: round robin with no locks
    do_reset();
    for (int k = 0; k < 8; k++) fill_pg(k);
    look_pg(0, 1'b1, "R6");
    look_pg(7, 1'b1, "R6");
    fill_pg(8);
    look_pg(0, 1'b0, "R6");
    look_pg(8, 1'b1, "R6");
    look_pg(1, 1'b1, "R6");

    // R10: lock two entries; pointer moves from 1 to 2
    do_lock(2);
    fill_pg(9);
    look_pg(2, 1'b0, "R10");
    look_pg(1, 1'b1, "R10");
    look_pg(9, 1'b1, "R10");

    // R6: wrap to the lock count
    for (int k = 10; k < 15; k++) fill_pg(k);
    fill_pg(15);
    look_pg(8, 1'b1, "R6");
    look_pg(9, 1'b0, "R6");
    look_pg(15, 1'b1, "R6");

    // R7: duplicate refill overwrites in place, pointer stays at 3
    fill(va_of(12), 2'b10, 32'hC000_0000, 4'hE, 8'hEE);
    lookup(va_of(12) + 32'h0AB, 1'b1, 32'hC000_00AB, 4'hE, 8'hEE, "R7");
    fill_pg(16);
    look_pg(10, 1'b0, "R7");
    look_pg(11, 1'b1, "R7");
    lookup(va_of(12) + 32'h0AB, 1'b1, 32'hC000_00AB, 4'hE, 8'hEE, "R7");

    // R9: refill matching a locked entry is dropped
    fill(va_of(8), 2'b10, 32'hDEAD_0000, 4'hD, 8'hDD);
    look_pg(8, 1'b1, "R9");

    // R8: flush spares locked entries
    do_flush();
    look_pg(8, 1'b1, "R8");
    look_pg(1, 1'b1, "R8");
    look_pg(16, 1'b0, "R8");
    look_pg(15, 1'b0, "R8");

    // R12: refill with flush or lock_set is dropped
    @(negedge clk);
    flush = 1'b1; set_fill(va_of(20), 2'b10, pa_of(20), dom_of(20), perm_of(20));
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    look_pg(20, 1'b0, "R12");
    @(negedge clk);
    lock_set = 1'b1; lock_count = 4'd2;
    set_fill(va_of(21), 2'b10, pa_of(21), dom_of(21), perm_of(21));
    @(negedge clk);
    lock_set = 1'b0; fill_valid = 1'b0;
    look_pg(21, 1'b0, "R12");

    // R11: lookup alongside refill sees old contents
    @(negedge clk);
    lkp_valid = 1'b1; lkp_vaddr = va_of(22) + 32'h0AB;
    push_exp(1'b0, 0, 0, 0, "R11");
    set_fill(va_of(22), 2'b10, pa_of(22), dom_of(22), perm_of(22));
    @(negedge clk);
    lkp_valid = 1'b0; fill_valid = 1'b0;
    look_pg(22, 1'b1, "R11");

    // R10: all locked, new refills dropped, flush has no effect
    do_lock(8);
    fill_pg(23);
    look_pg(23, 1'b0, "R10");
    do_flush();
    look_pg(22, 1'b1, "R10");
    do_lock(0);
    do_flush();
    look_pg(8, 1'b0, "R8");
    look_pg(1, 1'b0, "R8");
    look_pg(22, 1'b0, "R8");

    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d results missing, expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule